// File: doc/BRIEF.md
# Up/Down Timer with Two Capture/Reload Companions

The block holds one 16-bit core counter that steps up or down by one on each enabled clock, plus a one-bit toggle latch that flips whenever the counter wraps past either end of its range. Two companion registers sit beside it and never count. Each companion is set to one of four modes: idle, capture, reload on an input pin edge, or reload on a transition of the toggle latch.

In capture mode, a selected edge on the companion's input pin stores a snapshot of the core count and raises a flag. In the two reload modes, the core counter is loaded from the companion. The trigger is either a pin edge or the latch turning high or low. In latch-reload mode, the load takes the place of the wrapped value in the same clock.

When the counter runs down, one companion reloads on the latch turning high and the other on it turning low. The latch then carries a free-running PWM waveform with no software involvement. Its high time is the first companion plus one, and its low time is the second companion plus one, both counted in enabled ticks.

Top module: `tmr_caprel`

## Requirements
- R1: While `rst_n` is low, the core count, toggle latch, both companion values and both capture flags are zero.
- R2: With `cnt_en` high, the core count moves by one each clock: down when `cnt_down` is 1, up when it is 0. With `cnt_en` low it holds. A `core_wr` in a clock overrides any count or reload, and the count becomes `core_wdata` at that edge.
- R3: The toggle latch inverts on each wrap. A wrap is an enabled clock without `core_wr` that either counts up from all-ones or counts down from zero. The latch changes at no other time.
- R4: Mode code 2'b01 selects capture. Edge-select bit 0 enables rising edges and bit 1 enables falling edges, so 2'b11 selects both. The pin passes through two synchronising flops. A pin change presented before clock edge k takes effect at edge k+2, and the companion receives the core count held just before that edge.
- R5: If a capture and a companion write fall in the same clock, the capture is kept and the capture flag is set. A write with no capture loads the written data and clears the flag.
- R6: Mode code 2'b10 reloads the core count from the companion on a selected pin edge, with the same timing as R4. Companion 0 takes priority over companion 1, and `core_wr` takes priority over both.
- R7: Mode code 2'b11 reloads the core from the companion on a wrap. Edge-select bit 0 selects the wrap that turns the latch from 0 to 1, and bit 1 selects the wrap that turns it from 1 to 0. The reload value replaces the wrapped value in the same clock.
- R8: Set up the block as follows: companion 0 in mode 2'b11 with edge-select 2'b01, companion 1 in mode 2'b11 with edge-select 2'b10, counting down, `cnt_en` held high. The latch then stays high for companion 0 value + 1 clocks and low for companion 1 value + 1 clocks, without end.
- R9: A reload value of zero still gives a latch phase of one clock.
- R10: In mode 2'b00, pin edges are ignored. The companion value and the core count are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable for the core counter |
| cnt_down | input | 1 | 1 counts down, 0 counts up |
| core_wr | input | 1 | Write strobe for the core counter |
| core_wdata | input | 16 | Data for a core write |
| a0_mode | input | 2 | Companion 0 mode (00 idle, 01 capture, 10 pin reload, 11 latch reload) |
| a0_edge | input | 2 | Companion 0 edge select (bit 0 rising, bit 1 falling) |
| a0_pin | input | 1 | Companion 0 asynchronous trigger pin |
| a0_wr | input | 1 | Write strobe for companion 0 |
| a0_wdata | input | 16 | Data for a companion 0 write |
| a1_mode | input | 2 | Companion 1 mode |
| a1_edge | input | 2 | Companion 1 edge select |
| a1_pin | input | 1 | Companion 1 asynchronous trigger pin |
| a1_wr | input | 1 | Write strobe for companion 1 |
| a1_wdata | input | 16 | Data for a companion 1 write |
| core_cnt | output | 16 | Core counter value |
| tgl | output | 1 | Toggle latch; carries the PWM waveform |
| a0_val | output | 16 | Companion 0 value |
| a1_val | output | 16 | Companion 1 value |
| a0_capf | output | 1 | Companion 0 capture flag |
| a1_capf | output | 1 | Companion 1 capture flag |

## Verification
The bench drives the counter across both ends of its range, since a design that got the wrap detection wrong would drift the latch or skip a reload. It places a companion write in exactly the clock of a capture: a design with the wrong priority would lose the snapshot or leave the flag clear. It also measures latch run lengths in PWM operation, including with zero reload values. A design that reloaded a clock late, or treated zero as "no reload", would show phases one clock long or short, or a collapsed level. Finally, it toggles pins with a companion idle and with reloads racing a core write, to expose triggers that leak through the wrong mode.

// File: rtl/tmr_caprel.sv
module tmr_caprel #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         cnt_down,
  input  logic         core_wr,
  input  logic [W-1:0] core_wdata,
  input  logic [1:0]   a0_mode,
  input  logic [1:0]   a0_edge,
  input  logic         a0_pin,
  input  logic         a0_wr,
  input  logic [W-1:0] a0_wdata,
  input  logic [1:0]   a1_mode,
  input  logic [1:0]   a1_edge,
  input  logic         a1_pin,
  input  logic         a1_wr,
  input  logic [W-1:0] a1_wdata,
  output logic [W-1:0] core_cnt,
  output logic         tgl,
  output logic [W-1:0] a0_val,
  output logic [W-1:0] a1_val,
  output logic         a0_capf,
  output logic         a1_capf
);
  localparam logic [1:0] M_CAP = 2'b01;
  localparam logic [1:0] M_PRL = 2'b10;
  localparam logic [1:0] M_LRL = 2'b11;
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0]       core_q;
  logic               tgl_q;
  logic [1:0][W-1:0]  aux_q;
  logic [1:0]         capf_q;
  logic [1:0][2:0]    sync_q;

  logic [1:0][1:0]    mode, esel;
  logic [1:0][W-1:0]  wdat;
  logic [1:0]         pin, wr;
  logic [1:0]         hit, cap_ev, rl_ev;
  logic               wrap, lat_up, lat_dn;
  logic [W-1:0]       core_nx;

  assign mode = {a1_mode, a0_mode};
  assign esel = {a1_edge, a0_edge};
  assign wdat = {a1_wdata, a0_wdata};
  assign pin  = {a1_pin, a0_pin};
  assign wr   = {a1_wr, a0_wr};

  assign wrap   = cnt_en && !core_wr && (cnt_down ? (core_q == '0) : (core_q == TOP));
  assign lat_up = wrap && !tgl_q;
  assign lat_dn = wrap && tgl_q;

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      hit[i]    = (esel[i][0] && sync_q[i][1] && !sync_q[i][2]) ||
                  (esel[i][1] && !sync_q[i][1] && sync_q[i][2]);
      cap_ev[i] = (mode[i] == M_CAP) && hit[i];
      rl_ev[i]  = ((mode[i] == M_PRL) && hit[i]) ||
                  ((mode[i] == M_LRL) && ((esel[i][0] && lat_up) || (esel[i][1] && lat_dn)));
    end
  end

  always_comb begin
    if (core_wr)       core_nx = core_wdata;
    else if (rl_ev[0]) core_nx = aux_q[0];
    else if (rl_ev[1]) core_nx = aux_q[1];
    else if (cnt_en)   core_nx = cnt_down ? core_q - 1'b1 : core_q + 1'b1;
    else               core_nx = core_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q <= '0;
      tgl_q  <= 1'b0;
    end else begin
      core_q <= core_nx;
      if (wrap) tgl_q <= !tgl_q;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_aux
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        aux_q[g]  <= '0;
        capf_q[g] <= 1'b0;
        sync_q[g] <= '0;
      end else begin
        sync_q[g] <= {sync_q[g][1:0], pin[g]};
        if (cap_ev[g]) begin
          aux_q[g]  <= core_q;
          capf_q[g] <= 1'b1;
        end else if (wr[g]) begin
          aux_q[g]  <= wdat[g];
          capf_q[g] <= 1'b0;
        end
      end
    end
  end

  assign core_cnt = core_q;
  assign tgl      = tgl_q;
  assign a0_val   = aux_q[0];
  assign a1_val   = aux_q[1];
  assign a0_capf  = capf_q[0];
  assign a1_capf  = capf_q[1];
endmodule

module tmr_caprel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         cnt_down,
  input logic         core_wr,
  input logic [W-1:0] core_wdata,
  input logic [1:0]   a0_mode,
  input logic [1:0]   a0_edge,
  input logic         a0_pin,
  input logic         a0_wr,
  input logic [W-1:0] a0_wdata,
  input logic [1:0]   a1_mode,
  input logic [1:0]   a1_edge,
  input logic         a1_pin,
  input logic         a1_wr,
  input logic [W-1:0] a1_wdata,
  input logic [W-1:0] core_cnt,
  input logic         tgl,
  input logic [W-1:0] a0_val,
  input logic [W-1:0] a1_val,
  input logic         a0_capf,
  input logic         a1_capf
);
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |-> (core_cnt == '0 && !tgl && a0_val == '0 && a1_val == '0 && !a0_capf && !a1_capf));

  a_r2_core_write: assert property (@(posedge clk) disable iff (!rst_n)
    core_wr |=> core_cnt == $past(core_wdata));

  a_r3_toggle_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !core_wr && cnt_down && core_cnt == '0) |=> tgl != $past(tgl));

  a_r3_toggle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_en |=> $stable(tgl));

  a_r5_capture_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(a0_capf) |-> a0_val == $past(core_cnt));

  a_r7_latch_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !core_wr && cnt_down && core_cnt == '0 && !tgl && a0_mode == 2'b11 && a0_edge[0])
      |=> core_cnt == $past(a0_val));
endmodule

bind tmr_caprel tmr_caprel_chk #(.W(W)) u_chk (.*);

// File: tb/tmr_caprel_tb.sv
module tmr_caprel_tb;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_en = 1'b0, cnt_down = 1'b0, core_wr = 1'b0;
  logic [W-1:0] core_wdata = '0;
  logic [1:0] mode_i [2];
  logic [1:0] edge_i [2];
  logic pin_i [2];
  logic wr_i [2];
  logic [W-1:0] wdat_i [2];
  logic [W-1:0] core_cnt, a0_val, a1_val;
  logic tgl, a0_capf, a1_capf;

  int vectors = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_caprel #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_down(cnt_down),
    .core_wr(core_wr), .core_wdata(core_wdata),
    .a0_mode(mode_i[0]), .a0_edge(edge_i[0]), .a0_pin(pin_i[0]), .a0_wr(wr_i[0]), .a0_wdata(wdat_i[0]),
    .a1_mode(mode_i[1]), .a1_edge(edge_i[1]), .a1_pin(pin_i[1]), .a1_wr(wr_i[1]), .a1_wdata(wdat_i[1]),
    .core_cnt(core_cnt), .tgl(tgl), .a0_val(a0_val), .a1_val(a1_val),
    .a0_capf(a0_capf), .a1_capf(a1_capf));

  logic [W-1:0] m_core;
  logic [W-1:0] m_aux [2];
  logic m_tgl;
  logic m_capf [2];
  logic [2:0] m_sync [2];

  always @(posedge clk or negedge rst_n) begin : model
    logic w, lr, lf, r, f;
    logic [W-1:0] nc;
    logic h [2];
    if (!rst_n) begin
      m_core = '0; m_tgl = 0;
      for (int i = 0; i < 2; i++) begin m_aux[i] = '0; m_capf[i] = 0; m_sync[i] = '0; end
    end else begin
      w  = cnt_en && !core_wr && (cnt_down ? (m_core == '0) : (m_core == '1));
      lr = w && !m_tgl;
      lf = w && m_tgl;
      nc = m_core;
      if (cnt_en) nc = cnt_down ? m_core - 1 : m_core + 1;
      for (int i = 1; i >= 0; i--) begin
        r = m_sync[i][1] && !m_sync[i][2];
        f = !m_sync[i][1] && m_sync[i][2];
        h[i] = (edge_i[i][0] && r) || (edge_i[i][1] && f);
        if ((mode_i[i] == 2'd2 && h[i]) ||
            (mode_i[i] == 2'd3 && ((edge_i[i][0] && lr) || (edge_i[i][1] && lf))))
          nc = m_aux[i];
      end
      if (core_wr) nc = core_wdata;
      for (int i = 0; i < 2; i++) begin
        if (mode_i[i] == 2'd1 && h[i]) begin m_aux[i] = m_core; m_capf[i] = 1; end
        else if (wr_i[i]) begin m_aux[i] = wdat_i[i]; m_capf[i] = 0; end
        m_sync[i] = {m_sync[i][1:0], pin_i[i]};
      end
      if (w) m_tgl = !m_tgl;
      m_core = nc;
    end
  end

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2", core_cnt, m_core);
    chk("R3", {{(W-1){1'b0}}, tgl}, {{(W-1){1'b0}}, m_tgl});
    chk("R4", a0_val, m_aux[0]);
    chk("R4", a1_val, m_aux[1]);
    chk("R5", {{(W-1){1'b0}}, a0_capf}, {{(W-1){1'b0}}, m_capf[0]});
    chk("R5", {{(W-1){1'b0}}, a1_capf}, {{(W-1){1'b0}}, m_capf[1]});
  endtask

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare_all();
      core_wr = 0; wr_i[0] = 0; wr_i[1] = 0;
    end
  endtask

  task automatic pwm_run(string req, int hi, int lo);
    logic prev;
    int len, nt;
    prev = tgl; len = 0; nt = 0;
    for (int k = 0; k < 80; k++) begin
      step();
      len++;
      if (tgl != prev) begin
        if (nt >= 1) chk(req, len[W-1:0], prev ? hi[W-1:0] : lo[W-1:0]);
        nt++;
        len = 0;
        prev = tgl;
      end
    end
    chk(req, (nt >= 6) ? 16'd1 : 16'd0, 16'd1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 2; i++) begin
      mode_i[i] = 0; edge_i[i] = 0; pin_i[i] = 0; wr_i[i] = 0; wdat_i[i] = '0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", core_cnt, '0); chk("R1", a0_val, '0); chk("R1", a1_val, '0);
    chk("R1", {15'd0, tgl}, '0); chk("R1", {14'd0, a1_capf, a0_capf}, '0);
    rst_n = 1;
    step();

    // R2 R3 count up across the top, then down across zero
    core_wr = 1; core_wdata = 16'hFFFD; step();
    cnt_en = 1; step(5);
    chk("R3", {15'd0, tgl}, 16'd1);
    cnt_down = 1; step(6);
    chk("R3", {15'd0, tgl}, 16'd0);
    cnt_en = 0; step(3);
    chk("R2", core_cnt, m_core);

    // R4 capture on rising only, then both edges
    cnt_en = 1; cnt_down = 0;
    mode_i[0] = 2'b01; edge_i[0] = 2'b01;
    pin_i[0] = 1; step(4);
    chk("R5", {15'd0, a0_capf}, 16'd1);
    pin_i[0] = 0; step(4);
    mode_i[1] = 2'b01; edge_i[1] = 2'b11;
    pin_i[1] = 1; step(4);
    pin_i[1] = 0; step(4);
    mode_i[0] = 2'b01; edge_i[0] = 2'b10;
    pin_i[0] = 1; step(4); pin_i[0] = 0; step(4);

    // R5 capture beats a write in the same clock, then plain write clears flag
    edge_i[0] = 2'b01;
    wr_i[0] = 1; wdat_i[0] = 16'h0000; step();
    chk("R5", {15'd0, a0_capf}, 16'd0);
    pin_i[0] = 1; step(2);
    wr_i[0] = 1; wdat_i[0] = 16'h1234; step();
    chk("R5", {15'd0, a0_capf}, 16'd1);
    chk("R5", (a0_val == 16'h1234) ? 16'd1 : 16'd0, 16'd0);
    wr_i[0] = 1; wdat_i[0] = 16'h1234; step();
    chk("R5", a0_val, 16'h1234);
    chk("R5", {15'd0, a0_capf}, 16'd0);

    // R10 idle mode ignores pin edges
    mode_i[0] = 2'b00; edge_i[0] = 2'b11;
    pin_i[0] = 0; step(4); pin_i[0] = 1; step(4); pin_i[0] = 0; step(4);
    chk("R10", a0_val, 16'h1234);

    // R6 pin reload, priority of companion 0 and of a core write
    cnt_en = 0;
    wr_i[1] = 1; wdat_i[1] = 16'h0100; step();
    mode_i[1] = 2'b10; edge_i[1] = 2'b01;
    pin_i[1] = 1; step(3);
    chk("R6", core_cnt, 16'h0100);
    pin_i[1] = 0; step(3);
    mode_i[0] = 2'b10; edge_i[0] = 2'b01;
    pin_i[0] = 1; pin_i[1] = 1; step(3);
    chk("R6", core_cnt, 16'h1234);
    pin_i[0] = 0; pin_i[1] = 0; step(3);
    pin_i[1] = 1; step(2);
    core_wr = 1; core_wdata = 16'h0042; step();
    chk("R6", core_cnt, 16'h0042);
    pin_i[1] = 0; step(3);

    // R7 R8 PWM from two latch-triggered reloads
    mode_i[0] = 2'b00; mode_i[1] = 2'b00;
    wr_i[0] = 1; wdat_i[0] = 16'd5; wr_i[1] = 1; wdat_i[1] = 16'd2; step();
    mode_i[0] = 2'b11; edge_i[0] = 2'b01;
    mode_i[1] = 2'b11; edge_i[1] = 2'b10;
    cnt_down = 1; core_wr = 1; core_wdata = '0; step();
    cnt_en = 1;
    pwm_run("R8", 6, 3);
    chk("R7", core_cnt, m_core);

    // R9 zero reload values still give one-clock phases
    wr_i[0] = 1; wdat_i[0] = 16'd0; wr_i[1] = 1; wdat_i[1] = 16'd0; step();
    pwm_run("R9", 1, 1);

    // R7 only rising-latch reload: low phase runs the full range, check a few clocks
    mode_i[1] = 2'b00;
    wr_i[0] = 1; wdat_i[0] = 16'd3; step(20);

    finish_run();
  end
endmodule